// File: doc/BRIEF.md
# Three-Wire Serial Control Slave

This block is the slave side of a serial control port framed by a chip-enable line. A host controller raises the enable, toggles the serial clock and shifts data least significant bit first. Each frame opens with an 8-bit device address. The address decides the direction of the rest of the frame. A write frame carries payload bits from the master. A read frame carries status and monitor bits back from the slave on an open-drain data-out line. The serial clock may idle either high or low. Data is sampled on rising clock edges while enable is high, and read data changes on falling edges.

Enable, clock and data-in are brought into the system clock domain through synchronizers. Edges are detected on the synchronized copies. A write payload is gathered in a staging register. It is copied into the command holding register only when enable drops, and only if the frame length is one of the two accepted values. A busy flag marks an unread command. The host logic clears it with a one-cycle acknowledge.

Top module: `serial_ctrl_slave`

## Requirements
- R1: A frame whose 8-bit address is the write address (default 0xA6, first bit on the wire is address bit 0) and that closes after exactly 56 rising clock edges commits its 48 payload bits, so that the first payload bit lands in cmd_data_o[0]; upper cmd_data_o bits read 0 and cmd_long_o is 0.
- R2: A write frame that closes after exactly 200 rising edges commits all 192 payload bits, so that the last bit lands in cmd_data_o[191]; cmd_long_o is 1.
- R3: While enable stays high, cmd_data_o and busy_o do not change. A commit becomes visible only after enable falls.
- R4: A write frame that closes at any bit count other than 56 or 200 is discarded. busy_o stays low and cmd_data_o keeps its old value.
- R5: A frame whose address is neither the write address nor the read address (default 0xA7) changes no output, and do_oe_o stays 0.
- R6: In a frame addressed to the read address, the slave returns 56 bits, starting with the first bit after the address: status_i first, then mon_a_i, then mon_b_i, each least significant bit first. do_oe_o is 1 (pull low) exactly for the 0 bits. From bit 64 on, the line is released (do_oe_o is 0). The values are captured at the first falling edge after the address.
- R7: Writes and reads behave identically whether the clock idles high or idles low.
- R8: busy_o rises when a write commits and stays high until a one-cycle ack_i, which clears it on the next clock.
- R9: A write frame that closes while busy_o is high is discarded. The held command is unchanged.
- R10: After reset, busy_o, do_oe_o, cmd_long_o and cmd_data_o are all 0.
- R11: do_oe_o is 0 during write frames and from one cycle after enable is seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Frame enable from master, high during a frame |
| cl_i | input | 1 | Serial clock from master |
| di_i | input | 1 | Serial data from master |
| do_oe_o | output | 1 | Pull data-out low when 1, release when 0 |
| busy_o | output | 1 | A committed command is held |
| ack_i | input | 1 | One-cycle acknowledge that clears busy_o |
| cmd_data_o | output | 192 | Held command payload, first received bit at bit 0 |
| cmd_long_o | output | 1 | Held command came from a 200-bit frame |
| status_i | input | 8 | Status byte returned in read frames |
| mon_a_i | input | 24 | First monitor word returned in read frames |
| mon_b_i | input | 24 | Second monitor word returned in read frames |

## Verification
Write frames are sent with both clock idle levels and both accepted lengths. Payloads are chosen so that their bit positions are distinct, which shows whether bit order and alignment are right. Frames closed at 55 and 57 bits test the length check from both sides. A frame to a foreign address and a frame sent while a command is held test that such frames leave the outputs alone. Read frames in both polarities return a status and monitor pattern with mixed bits. Extra clocks past the 64th bit show that the line is released once the data runs out.

// File: rtl/scs_pkg.sv
package scs_pkg;
  typedef enum logic [1:0] {
    FK_IDLE    = 2'd0,
    FK_WRITE   = 2'd1,
    FK_READ    = 2'd2,
    FK_FOREIGN = 2'd3
  } frame_kind_e;
endpackage

// File: rtl/scs_sync.sv
module scs_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q[0] <= '0;
    else         st_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[g] <= '0;
      else         st_q[g] <= st_q[g-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/scs_frame_ctl.sv
module scs_frame_ctl
  import scs_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter logic [7:0]  WR_ADDR = 8'hA6,
  parameter logic [7:0]  RD_ADDR = 8'hA7,
  parameter int          CNT_MAX = 201,
  parameter int          CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             cl_i,
  input  logic             di_i,
  output logic             rise_o,
  output logic             fall_o,
  output logic             open_o,
  output logic             close_o,
  output logic [CNT_W-1:0] cnt_o,
  output frame_kind_e      kind_o
);
  logic              ce_q, cl_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;

  assign open_o  = ce_i & ~ce_q;
  assign close_o = ~ce_i & ce_q;
  // both edges need enable seen high on this and the previous cycle
  assign rise_o  = ce_i & ce_q & cl_i & ~cl_q;
  assign fall_o  = ce_i & ce_q & ~cl_i & cl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q   <= 1'b0;
      cl_q   <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
    end else begin
      ce_q <= ce_i;
      cl_q <= cl_i;
      if (open_o) begin
        cnt_q  <= '0;
        addr_q <= '0;
      end else if (rise_o) begin
        if (cnt_q < CNT_W'(ADDR_W)) addr_q <= {di_i, addr_q[ADDR_W-1:1]};
        if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    kind_o = FK_IDLE;
    if (cnt_q >= CNT_W'(ADDR_W)) begin
      if (addr_q == WR_ADDR)      kind_o = FK_WRITE;
      else if (addr_q == RD_ADDR) kind_o = FK_READ;
      else                        kind_o = FK_FOREIGN;
    end
  end

  assign cnt_o = cnt_q;

  AST_CNT_ONLY_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_o && !open_o) |=> $stable(cnt_q)); // R1
endmodule

// File: rtl/scs_rx_buffer.sv
module scs_rx_buffer
  import scs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_S  = 56,
  parameter int LEN_L  = 200,
  parameter int PAY_W  = LEN_L - ADDR_W,
  parameter int CNT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             open_i,
  input  logic             close_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  frame_kind_e      kind_i,
  input  logic             di_i,
  input  logic             ack_i,
  output logic [PAY_W-1:0] cmd_o,
  output logic             long_o,
  output logic             busy_o
);
  logic [PAY_W-1:0] stg_q, cmd_q;
  logic             long_q, busy_q;
  logic [CNT_W-1:0] idx;
  logic             in_pay, len_ok, commit;

  assign idx    = cnt_i - CNT_W'(ADDR_W);
  assign in_pay = (cnt_i >= CNT_W'(ADDR_W)) && (cnt_i < CNT_W'(ADDR_W + PAY_W));
  assign len_ok = (cnt_i == CNT_W'(LEN_S)) || (cnt_i == CNT_W'(LEN_L));
  assign commit = close_i && (kind_i == FK_WRITE) && len_ok && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= '0;
      cmd_q  <= '0;
      long_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (open_i) stg_q <= '0;
      else if (rise_i && in_pay && kind_i == FK_WRITE) stg_q[idx] <= di_i;
      if (commit) begin
        cmd_q  <= stg_q;
        long_q <= (cnt_i == CNT_W'(LEN_L));
        busy_q <= 1'b1;
      end else if (ack_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign cmd_o  = cmd_q;
  assign long_o = long_q;
  assign busy_o = busy_q;

  AST_BUSY_AT_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(close_i)); // R3
  AST_BUSY_LEN_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(cnt_i == CNT_W'(LEN_S) || cnt_i == CNT_W'(LEN_L))); // R4
  AST_HELD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(cmd_q)); // R9
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && busy_q) |=> !busy_q); // R8
endmodule

// File: rtl/scs_tx_shift.sv
module scs_tx_shift
  import scs_pkg::*;
#(
  parameter int RD_W = 56
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ce_i,
  input  logic            fall_i,
  input  frame_kind_e     kind_i,
  input  logic [RD_W-1:0] word_i,
  output logic            do_oe_o
);
  logic            armed_q, out_q;
  logic [RD_W-2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      out_q   <= 1'b1;
      sh_q    <= '1;
    end else if (!ce_i) begin
      armed_q <= 1'b0;
      out_q   <= 1'b1;
      sh_q    <= '1;
    end else if (fall_i && kind_i == FK_READ) begin
      if (!armed_q) begin
        // snapshot at the first falling edge after the address
        armed_q <= 1'b1;
        out_q   <= word_i[0];
        sh_q    <= word_i[RD_W-1:1];
      end else begin
        out_q <= sh_q[0];
        sh_q  <= {1'b1, sh_q[RD_W-2:1]};
      end
    end
  end

  assign do_oe_o = ~out_q;

  AST_DO_RELEASED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> !do_oe_o); // R11
  AST_DRIVE_ONLY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_oe_o |-> (kind_i == FK_READ)); // R5
endmodule

// File: rtl/serial_ctrl_slave.sv
module serial_ctrl_slave
  import scs_pkg::*;
#(
  parameter logic [7:0] WR_ADDR     = 8'hA6,
  parameter logic [7:0] RD_ADDR     = 8'hA7,
  parameter int         ADDR_W      = 8,
  parameter int         LEN_S       = 56,
  parameter int         LEN_L       = 200,
  parameter int         STAT_W      = 8,
  parameter int         MON_W       = 24,
  parameter int         SYNC_STAGES = 2,
  localparam int        PAY_W       = LEN_L - ADDR_W,
  localparam int        RD_W        = STAT_W + 2 * MON_W,
  localparam int        CNT_MAX     = LEN_L + 1,
  localparam int        CNT_W       = $clog2(CNT_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              cl_i,
  input  logic              di_i,
  output logic              do_oe_o,
  output logic              busy_o,
  input  logic              ack_i,
  output logic [PAY_W-1:0]  cmd_data_o,
  output logic              cmd_long_o,
  input  logic [STAT_W-1:0] status_i,
  input  logic [MON_W-1:0]  mon_a_i,
  input  logic [MON_W-1:0]  mon_b_i
);
  logic [2:0]       pins_s;
  logic             rise, fall, open_f, close_f;
  logic [CNT_W-1:0] cnt;
  frame_kind_e      kind;

  scs_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ce_i, cl_i, di_i}),
    .q_o   (pins_s)
  );

  scs_frame_ctl #(
    .ADDR_W (ADDR_W),
    .WR_ADDR(WR_ADDR),
    .RD_ADDR(RD_ADDR),
    .CNT_MAX(CNT_MAX),
    .CNT_W  (CNT_W)
  ) i_frame_ctl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_i   (pins_s[2]),
    .cl_i   (pins_s[1]),
    .di_i   (pins_s[0]),
    .rise_o (rise),
    .fall_o (fall),
    .open_o (open_f),
    .close_o(close_f),
    .cnt_o  (cnt),
    .kind_o (kind)
  );

  scs_rx_buffer #(
    .ADDR_W(ADDR_W),
    .LEN_S (LEN_S),
    .LEN_L (LEN_L),
    .PAY_W (PAY_W),
    .CNT_W (CNT_W)
  ) i_rx_buffer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (rise),
    .open_i (open_f),
    .close_i(close_f),
    .cnt_i  (cnt),
    .kind_i (kind),
    .di_i   (pins_s[0]),
    .ack_i  (ack_i),
    .cmd_o  (cmd_data_o),
    .long_o (cmd_long_o),
    .busy_o (busy_o)
  );

  scs_tx_shift #(.RD_W(RD_W)) i_tx_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_i   (pins_s[2]),
    .fall_i (fall),
    .kind_i (kind),
    .word_i ({mon_b_i, mon_a_i, status_i}),
    .do_oe_o(do_oe_o)
  );
endmodule

// File: tb/test_serial_ctrl_slave.sv
module test_serial_ctrl_slave;
  localparam int CLK_P = 10;
  localparam int HALF  = 8;
  localparam logic [7:0] WR_A = 8'hA6;
  localparam logic [7:0] RD_A = 8'hA7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce = 1'b0, cl = 1'b0, di = 1'b0, ack = 1'b0;
  logic [7:0]   status = '0;
  logic [23:0]  mon_a = '0, mon_b = '0;
  logic         do_oe, busy, cmd_long;
  logic [191:0] cmd;

  int total = 0, bad = 0;
  bit done = 0;
  logic [255:0] fb;
  logic [255:0] samp;
  bit any_drv;

  always #(CLK_P/2) clk = ~clk;

  serial_ctrl_slave i_serial_ctrl_slave (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .cl_i(cl), .di_i(di),
    .do_oe_o(do_oe), .busy_o(busy), .ack_i(ack),
    .cmd_data_o(cmd), .cmd_long_o(cmd_long),
    .status_i(status), .mon_a_i(mon_a), .mon_b_i(mon_b)
  );

  task automatic chk(string req, logic [191:0] act, logic [191:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_clks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (do_oe) any_drv = 1;
    end
  endtask

  // sends nbits from fb; samp[k] = do_oe seen just before the k-th rising edge
  task automatic send_bits(int nbits, bit idle_hi);
    any_drv = 0;
    samp = '0;
    cl = idle_hi;
    wait_clks(HALF);
    ce = 1'b1;
    wait_clks(HALF);
    for (int k = 0; k < nbits; k++) begin
      if (idle_hi) cl = 1'b0;
      di = fb[k];
      wait_clks(HALF);
      samp[k] = do_oe;
      cl = 1'b1;
      wait_clks(HALF);
      if (!idle_hi) begin
        cl = 1'b0;
        wait_clks(HALF);
      end
    end
  endtask

  task automatic close_frame();
    ce = 1'b0;
    wait_clks(6);
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    wait_clks(2);
  endtask

  task automatic t_reset();
    chk("R10 busy", 192'(busy), 192'd0);
    chk("R10 do_oe", 192'(do_oe), 192'd0);
    chk("R10 long", 192'(cmd_long), 192'd0);
    chk("R10 cmd", cmd, 192'd0);
  endtask

  task automatic t_short_write();
    logic [47:0] p = 48'h8123_4567_89A1;
    fb = '0;
    fb[7:0] = WR_A;
    fb[55:8] = p;
    send_bits(56, 1'b1);
    wait_clks(6);
    chk("R3 busy before close", 192'(busy), 192'd0);
    chk("R3 cmd before close", cmd, 192'd0);
    close_frame();
    chk("R8 busy after commit", 192'(busy), 192'd1);
    chk("R1 cmd", cmd, 192'(p));
    chk("R1 long", 192'(cmd_long), 192'd0);
    chk("R11 no drive on write", 192'(any_drv), 192'd0);
  endtask

  task automatic t_busy_block();
    fb = '0;
    fb[7:0] = WR_A;
    fb[55:8] = 48'h0F0F_F0F0_5555;
    send_bits(56, 1'b1);
    close_frame();
    chk("R9 cmd kept", cmd, 192'(48'h8123_4567_89A1));
    chk("R9 busy kept", 192'(busy), 192'd1);
    wait_clks(20);
    chk("R8 busy holds", 192'(busy), 192'd1);
    pulse_ack();
    chk("R8 ack clears", 192'(busy), 192'd0);
  endtask

  task automatic t_long_write();
    logic [191:0] p = {64'hC3A5_0011_2233_4455, 64'h6677_8899_AABB_CCDD, 64'hEEFF_1357_9BDF_2468};
    fb = '0;
    fb[7:0] = WR_A;
    fb[199:8] = p;
    send_bits(200, 1'b0);
    close_frame();
    chk("R2 R7 cmd", cmd, p);
    chk("R2 long", 192'(cmd_long), 192'd1);
    chk("R2 busy", 192'(busy), 192'd1);
    pulse_ack();
  endtask

  task automatic t_bad_len(int n);
    logic [191:0] prev = cmd;
    fb = '1;
    fb[7:0] = WR_A;
    send_bits(n, 1'b1);
    close_frame();
    chk($sformatf("R4 busy len %0d", n), 192'(busy), 192'd0);
    chk($sformatf("R4 cmd len %0d", n), cmd, prev);
  endtask

  task automatic t_foreign();
    logic [191:0] prev = cmd;
    fb = '0;
    fb[7:0] = 8'h3C;
    send_bits(64, 1'b0);
    close_frame();
    chk("R5 busy", 192'(busy), 192'd0);
    chk("R5 cmd", cmd, prev);
    chk("R5 no drive", 192'(any_drv), 192'd0);
  endtask

  task automatic t_read(bit idle_hi, logic [7:0] s, logic [23:0] a, logic [23:0] b);
    logic [55:0] w = {b, a, s};
    int errs = 0;
    status = s; mon_a = a; mon_b = b;
    fb = '1;
    fb[7:0] = RD_A;
    send_bits(70, idle_hi);
    for (int k = 8; k < 64; k++) if (samp[k] !== ~w[k-8]) errs++;
    chk($sformatf("R6 R7 read data idle_hi=%0d mismatches", idle_hi), 192'(errs), 192'd0);
    chk("R6 released after data", 192'(samp[69:64]), 192'd0);
    chk("R6 quiet during address", 192'(samp[7:0]), 192'd0);
    close_frame();
    chk("R11 released after close", 192'(do_oe), 192'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_clks(2);
    t_reset();
    t_short_write();
    t_busy_block();
    t_long_write();
    t_bad_len(55);
    t_bad_len(57);
    t_foreign();
    t_read(1'b1, 8'hA5, 24'h0F33C6, 24'h81_7E_24);
    t_read(1'b0, 8'h3C, 24'hF00F5A, 24'h12_3456);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule